// File: doc/BRIEF.md
# Routable Interrupt Aggregation Controller

This block gathers a bank of level-sensitive interrupt inputs and steers each of them onto one of several parent interrupt lines. Every input owns a 4-bit routing field; the field picks which output line the input drives, and a zero field leaves the input connected to nothing. A global enable mask qualifies the inputs, and a read-only status word shows their raw levels. An input counts as pending only when it is both high and enabled.

Software uses a plain 32-bit register port: one write strobe, a word address, write data and registered read data. The routing fields are packed eight to a register. The register order is reversed, so the lowest-addressed routing register holds the highest-numbered inputs. Before it assigns an input, software can read a field back to see whether the input is already routed. Each output line is a register holding the OR of all pending inputs routed to it.

Top module: `irq_route_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable mask, all four routing registers, the read data and every output line to zero.
- R2: Offset 0x00 holds the enable mask and reads back what was last written. Offset 0x04 reads the current level of each input (bit n = input n). Read data appears one clock after the address is presented.
- R3: The routing registers sit at offsets 0x08, 0x0C, 0x10 and 0x14 and read back as written. Input n's field is in the register at offset 0x08 + 4*(3 - n/8), bits [(n mod 8)*4 +: 4]. So inputs 24..31 are at 0x08 and inputs 0..7 are at 0x14.
- R4: An input whose routing field is 0 drives no output line, whatever its level and mask.
- R5: A routing field value v in 1..15 connects the input to output line v-1.
- R6: An input is pending only when its input level and its mask bit are both 1. Each output line is the OR of all pending inputs routed to it.
- R7: While the enable mask is zero, every output line is low.
- R8: Each output line reflects the inputs, mask and routing registers as they stood at the previous clock edge, so it has one cycle of latency.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets, or to the status offset 0x04, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| irq_in | input | 32 | Level interrupt inputs |
| irq_out | output | 15 | Routed parent interrupt lines |

## Verification
Every result of this block is due exactly one clock after its cause. A read returns data for the address held at the previous rising edge. An output line reflects the levels, mask and routing present at that edge. A register write made at an edge reaches the outputs one edge later. The bench drives stimulus on falling edges and updates a behavioural model on rising edges. On each falling edge it compares the outputs and the read data against the model's one-cycle-delayed predictions. Directed checks also confirm that the old value still holds before the due edge and the new one right after it.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int OFF_MASK = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_RT0  = 'h08;
endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
// Register file: enable mask, routing words, read mux with one cycle latency.
module irq_route_regs #(
  parameter int N_IN = 32,
  parameter int DW   = 32,
  parameter int N_RT = 4,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [N_IN-1:0] irq_in,
  output logic [N_IN-1:0] mask_q,
  output logic [DW-1:0]   rt_q [N_RT],
  output logic [DW-1:0]   rd_q
);
  import irq_route_pkg::*;

  localparam int RT_LAST = OFF_RT0 + 4 * (N_RT - 1);

  logic [DW-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (addr == AW'(OFF_MASK)) rd_nxt = DW'(mask_q);
    if (addr == AW'(OFF_STAT)) rd_nxt = DW'(irq_in);
    for (int r = 0; r < N_RT; r++) begin
      if (addr == AW'(OFF_RT0 + 4 * r)) rd_nxt = rt_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rd_q   <= '0;
      for (int r = 0; r < N_RT; r++) rt_q[r] <= '0;
    end else begin
      rd_q <= rd_nxt;
      if (wr_en) begin
        if (addr == AW'(OFF_MASK)) mask_q <= wdata[N_IN-1:0];
        for (int r = 0; r < N_RT; r++) begin
          if (addr == AW'(OFF_RT0 + 4 * r)) rt_q[r] <= wdata;
        end
      end
    end
  end

  // R2: a mask write is visible in the mask register at the next edge
  a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFF_MASK)) |=> (mask_q == $past(wdata[N_IN-1:0])));

  // R9: writing the status offset leaves mask and routing untouched
  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFF_STAT)) |=> ($stable(mask_q) && $stable(rt_q[0])
                                         && $stable(rt_q[N_RT-1])));

  // R9: unmapped addresses read as zero
  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    !(addr == AW'(OFF_MASK) || addr == AW'(OFF_STAT) ||
      (addr >= AW'(OFF_RT0) && addr <= AW'(RT_LAST) && addr[1:0] == 2'b00))
    |=> (rd_q == '0));
endmodule

// File: rtl/irq_route_fields.sv
`timescale 1ns/1ps
// Unpacks the reverse-ordered routing words into one field per input.
module irq_route_fields #(
  parameter int N_IN = 32,
  parameter int DW   = 32,
  parameter int FW   = 4,
  parameter int N_RT = 4
) (
  input  logic [DW-1:0]   rt_q [N_RT],
  output logic [FW-1:0]   fld  [N_IN],
  output logic [N_IN-1:0] routed
);
  for (genvar n = 0; n < N_IN; n++) begin : g_field
    localparam int WORD = N_RT - 1 - (n * FW) / DW;
    localparam int LSB  = (n * FW) % DW;
    assign fld[n]    = rt_q[WORD][LSB +: FW];
    assign routed[n] = (rt_q[WORD][LSB +: FW] != '0);
  end
endmodule

// File: rtl/irq_route_outmux.sv
`timescale 1ns/1ps
// Per-output selection and registered OR of pending inputs.
module irq_route_outmux #(
  parameter int N_IN  = 32,
  parameter int N_OUT = 15,
  parameter int FW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  pend,
  input  logic [FW-1:0]    fld [N_IN],
  input  logic [N_IN-1:0]  routed,
  output logic [N_OUT-1:0] out_q
);
  logic [N_OUT-1:0] hit;

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    logic [N_IN-1:0] sel;
    always_comb begin
      for (int n = 0; n < N_IN; n++) sel[n] = (fld[n] == FW'(k + 1));
    end
    assign hit[k] = |(sel & pend);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= hit;
  end

  // R4: with no pending input carrying a nonzero field, all lines drop
  a_r4_unrouted_silent: assert property (@(posedge clk) disable iff (rst)
    ((pend & routed) == '0) |=> (out_q == '0));

  // R5: a raised line needs some pending routed input one cycle earlier
  a_r5_line_has_source: assert property (@(posedge clk) disable iff (rst)
    (out_q != '0) |-> ($past(pend & routed) != '0));
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
// Top: register port, field unpacking, masking and routed outputs.
module irq_route_ctrl #(
  parameter int N_IN  = 32,
  parameter int N_OUT = 15,
  parameter int FW    = 4,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  input  logic [N_IN-1:0]  irq_in,
  output logic [N_OUT-1:0] irq_out
);
  localparam int N_RT = (N_IN * FW) / DW;

  logic [N_IN-1:0] mask_q;
  logic [DW-1:0]   rt_q [N_RT];
  logic [FW-1:0]   fld  [N_IN];
  logic [N_IN-1:0] routed;
  logic [N_IN-1:0] pend;

  irq_route_regs #(.N_IN(N_IN), .DW(DW), .N_RT(N_RT), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_in(irq_in), .mask_q(mask_q), .rt_q(rt_q), .rd_q(rd_data)
  );

  irq_route_fields #(.N_IN(N_IN), .DW(DW), .FW(FW), .N_RT(N_RT)) u_fields (
    .rt_q(rt_q), .fld(fld), .routed(routed)
  );

  assign pend = irq_in & mask_q;

  irq_route_outmux #(.N_IN(N_IN), .N_OUT(N_OUT), .FW(FW)) u_outmux (
    .clk(clk), .rst(rst), .pend(pend), .fld(fld), .routed(routed), .out_q(irq_out)
  );

  // R7: an all-zero mask silences every line on the next edge
  a_r7_mask_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (irq_out == '0));
endmodule

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic [31:0] irq_in;
  logic [14:0] irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
  );

  // behavioural reference state
  logic [31:0] m_mask;
  logic [31:0] m_rt [4];
  logic [14:0] exp_out;
  logic [31:0] exp_rd;
  bit          model_live = 0;

  function automatic logic [14:0] model_lines();
    logic [14:0] o = '0;
    for (int n = 0; n < 32; n++) begin
      int f;
      f = int'((m_rt[3 - n / 8] >> ((n % 8) * 4)) & 32'hF);
      if (f != 0 && m_mask[n] && irq_in[n]) o[f - 1] = 1'b1;
    end
    return o;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return m_mask;
      8'h04: return irq_in;
      8'h08: return m_rt[0];
      8'h0C: return m_rt[1];
      8'h10: return m_rt[2];
      8'h14: return m_rt[3];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0;
      for (int r = 0; r < 4; r++) m_rt[r] = '0;
      exp_out = '0;
      exp_rd  = '0;
    end else begin
      exp_out = model_lines();
      exp_rd  = model_read(addr);
      if (wr_en) begin
        case (addr)
          8'h00: m_mask = wdata;
          8'h08: m_rt[0] = wdata;
          8'h0C: m_rt[1] = wdata;
          8'h10: m_rt[2] = wdata;
          8'h14: m_rt[3] = wdata;
          default: ;
        endcase
      end
    end
    model_live = 1;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model (R6, R8 for lines; R2 for reads)
  always @(negedge clk) begin
    if (model_live && !done) begin
      chk("R8 per-cycle irq_out", 32'(irq_out), 32'(exp_out));
      chk("R2 per-cycle rd_data", rd_data, exp_rd);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; irq_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 lines after reset", 32'(irq_out), 0);
    rd(8'h00, v); chk("R1 mask after reset", v, 0);
    rd(8'h08, v); chk("R1 route word 0x08 after reset", v, 0);
    rd(8'h14, v); chk("R1 route word 0x14 after reset", v, 0);

    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 mask readback", v, 32'hFFFF_FFFF);
    irq_in = 32'hA5A5_0F0F;
    rd(8'h04, v); chk("R2 status level", v, 32'hA5A5_0F0F);
    chk("R4 unrouted inputs drive nothing", 32'(irq_out), 0);
    irq_in = '0;

    // input 24 -> field value 3 -> line 2
    wr(8'h08, 32'h0000_0003);
    rd(8'h08, v); chk("R3 route word readback", v, 32'h0000_0003);
    @(negedge clk);
    irq_in[24] = 1'b1;
    chk("R8 line not yet raised", 32'(irq_out), 0);
    @(negedge clk);
    chk("R5 input24 on line2", 32'(irq_out), 32'h0004);

    // input 0 -> 15 -> line 14, input 7 -> 1 -> line 0
    wr(8'h14, 32'h1000_000F);
    irq_in = (32'h1 << 24) | 32'h1 | (32'h1 << 7);
    @(negedge clk);
    chk("R5 extreme field values", 32'(irq_out), 32'h4005);

    // input 8 in word 0x10, input 16 in word 0x0C
    wr(8'h10, 32'h0000_0002);
    wr(8'h0C, 32'h0000_0005);
    irq_in = (32'h1 << 8) | (32'h1 << 16);
    @(negedge clk);
    chk("R3 reverse word order", 32'(irq_out), 32'h0012);

    // inputs 8 and 9 share line 1
    wr(8'h10, 32'h0000_0022);
    irq_in = 32'h1 << 9;
    @(negedge clk);
    chk("R6 second input on shared line", 32'(irq_out), 32'h0002);
    irq_in = (32'h1 << 8) | (32'h1 << 9);
    @(negedge clk);
    chk("R6 OR of two inputs", 32'(irq_out), 32'h0002);

    // mask gates a single input
    irq_in = 32'h1 << 24;
    @(negedge clk);
    chk("R6 masked-in input", 32'(irq_out), 32'h0004);
    wr(8'h00, ~(32'h1 << 24));
    @(negedge clk);
    chk("R6 masked-out input", 32'(irq_out), 0);

    irq_in = 32'hFFFF_FFFF;
    wr(8'h00, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6 all routed lines", 32'(irq_out), 32'h4017);
    wr(8'h00, 32'h0);
    @(negedge clk);
    chk("R7 zero mask silences lines", 32'(irq_out), 0);

    wr(8'h04, 32'h1234_5678);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R9 mask unchanged", v, 0);
    rd(8'h08, v); chk("R9 route word unchanged", v, 32'h0000_0003);
    rd(8'h18, v); chk("R9 unmapped read", v, 0);
    rd(8'h09, v); chk("R9 misaligned read", v, 0);
    chk("R9 lines stay low", 32'(irq_out), 0);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 lines after second reset", 32'(irq_out), 0);
    rd(8'h14, v); chk("R1 route word cleared", v, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] offs [9];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h3C, 8'h0A};
      @(negedge clk);
      addr   = offs[$urandom_range(0, 8)];
      wdata  = $urandom;
      wr_en  = ($urandom_range(0, 3) == 0);
      irq_in = $urandom;
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule